// File: doc/BRIEF.md
# Pulse-Swallow Dual-Modulus Frequency Divider

This block divides a fast input clock by a programmable 16-bit ratio. It uses the pulse-swallow scheme. A prescaler model counts input cycles in groups of 32 or 33, chosen by a modulus-select line. Behind the prescaler sit two counters: a 5-bit swallow counter A and an 11-bit main counter B. During each output period, the first A prescaler groups are 33 cycles long and the remaining B−A groups are 32 cycles long. The period is therefore M = 32·B + A input cycles. At the end of every period, the block issues one pulse that is one cycle wide. This pulse is the divided feedback clock for a phase detector.

The ratio word is sampled only at period boundaries, so software can rewrite it at any time without creating a short or long period. Continuous counting needs B ≥ A. With a 5-bit A, this holds for every B of at least 31. The block therefore clamps any word below 992 (that is, B < 31) to exactly 992 and flags the clamp. Driving the run input low puts the divider in standby: counting stops and the counters return to the start of a fresh period.

Top module: `pswdiv_top`

## Requirements
- R1: With a legal ratio word W (992 ≤ W ≤ 65535; upper 11 bits B, lower 5 bits A), consecutive output pulses are exactly W input cycles apart, i.e. 32·B + A.
- R2: Every output pulse is high for exactly one input cycle.
- R3: After reset is released or standby is left, with run high, the first pulse appears after exactly M rising edges, counted from the first running edge, where M is the ratio (after clamping) present on the ratio input at that moment.
- R4: Changing the ratio word in the middle of a period leaves that period's length unchanged; the new value takes effect from the next period boundary.
- R5: A ratio word below 992 (main count under 31, which covers every case of B < A) is replaced by 992. The error output is 1 while a clamped ratio is in force and 0 while a legal ratio is in force. It updates at the boundary where the ratio is loaded.
- R6: While run is low, no pulse is produced and the counters are held at the start of a period loaded from the current ratio input.
- R7: While synchronous reset is high, the pulse output is 0. For a legal ratio on the input, the error output is also 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Input clock that is being divided |
| rst_i | input | 1 | Synchronous reset, active high |
| run_i | input | 1 | 1 = count, 0 = standby (counters stopped and re-armed) |
| ratio_i | input | 16 | Ratio word: bits 15:5 main count B, bits 4:0 swallow count A |
| pulse_o | output | 1 | One-cycle pulse at the end of every divided period |
| ratio_err_o | output | 1 | 1 while the ratio in force was clamped to the minimum |

## Verification
A ratio present at a boundary edge governs the period that starts on that edge. Its pulse appears in the register after the M-th following edge, so the bench counts falling edges from the last pulse, or from release of reset or standby, and expects the count to equal M exactly. A ratio written just after a pulse is therefore not yet in force: the bench expects the period then running to keep the previous length and checks the new length one period later. The error flag is loaded on the same boundary edge as the ratio, so it is compared at the falling edge where the pulse that started the new ratio's period is seen. All samples are taken on falling edges, half a period away from the edges that change the design's state.

// File: rtl/pswdiv_pkg.sv
package pswdiv_pkg;

  // Default prescaler modulus (low value) and main-counter width.
  localparam int unsigned PRE_MOD_DEF = 32;
  localparam int unsigned B_W_DEF     = 11;

  // Period in input cycles for main count b and swallow count a.
  function automatic int unsigned ratio_of(input int unsigned b,
                                           input int unsigned a,
                                           input int unsigned pre_mod);
    return pre_mod * b + a;
  endfunction

  // Smallest ratio that still counts without gaps.
  function automatic int unsigned min_ratio(input int unsigned pre_mod);
    return pre_mod * (pre_mod - 1);
  endfunction

  // Main count must cover every swallow group and reach pre_mod-1.
  function automatic bit ratio_legal(input int unsigned b,
                                     input int unsigned a,
                                     input int unsigned pre_mod);
    return (b >= pre_mod - 1) && (b >= a);
  endfunction

endpackage

// File: rtl/pswdiv_ratio_guard.sv
module pswdiv_ratio_guard #(
  parameter int unsigned PRE_MOD = pswdiv_pkg::PRE_MOD_DEF,
  parameter int unsigned B_W     = pswdiv_pkg::B_W_DEF
) (
  input  logic [$clog2(PRE_MOD)+B_W-1:0] word_i,
  output logic [$clog2(PRE_MOD)-1:0]     a_o,
  output logic [B_W-1:0]                 b_o,
  output logic                           clamp_o
);
  localparam int unsigned A_W = $clog2(PRE_MOD);
  localparam int unsigned N_W = A_W + B_W;

  logic [A_W-1:0] a_raw;
  logic [B_W-1:0] b_raw;
  logic           legal;

  assign a_raw = word_i[A_W-1:0];
  assign b_raw = word_i[N_W-1:A_W];
  assign legal = pswdiv_pkg::ratio_legal(int'(b_raw), int'(a_raw), PRE_MOD);

  // Illegal words fall back to the smallest continuous ratio.
  assign b_o     = legal ? b_raw : B_W'(PRE_MOD - 1);
  assign a_o     = legal ? a_raw : '0;
  assign clamp_o = ~legal;
endmodule

// File: rtl/pswdiv_prescaler.sv
module pswdiv_prescaler #(
  parameter int unsigned PRE_MOD = pswdiv_pkg::PRE_MOD_DEF
) (
  input  logic clk_i,
  input  logic start_i,      // hold at the first cycle of a group
  input  logic step_i,       // count enable
  input  logic mod_hi_next_i,// modulus of the group that loads now
  output logic pre_tick_o    // last cycle of a group
);
  localparam int unsigned PC_W = $clog2(PRE_MOD + 1);
  localparam logic [PC_W-1:0] TOP_HI = PC_W'(PRE_MOD);      // PRE_MOD+1 cycles
  localparam logic [PC_W-1:0] TOP_LO = PC_W'(PRE_MOD - 1);  // PRE_MOD cycles

  logic [PC_W-1:0] phase_q;
  logic [PC_W-1:0] reload_val;

  assign reload_val = mod_hi_next_i ? TOP_HI : TOP_LO;
  assign pre_tick_o = step_i && !start_i && (phase_q == '0);

  always_ff @(posedge clk_i) begin
    if (start_i) begin
      phase_q <= reload_val;
    end else if (step_i) begin
      if (phase_q == '0) phase_q <= reload_val;
      else               phase_q <= phase_q - PC_W'(1);
    end
  end

  // R1: the phase counter never leaves its range.
  assert_phase_range_R1: assert property (@(posedge clk_i) disable iff (start_i)
    phase_q <= TOP_HI);
endmodule

// File: rtl/pswdiv_swallow_seq.sv
module pswdiv_swallow_seq #(
  parameter int unsigned PRE_MOD = pswdiv_pkg::PRE_MOD_DEF,
  parameter int unsigned B_W     = pswdiv_pkg::B_W_DEF
) (
  input  logic                       clk_i,
  input  logic                       start_i,
  input  logic                       pre_tick_i,
  input  logic [$clog2(PRE_MOD)-1:0] a_new_i,
  input  logic [B_W-1:0]             b_new_i,
  input  logic                       clamp_new_i,
  output logic                       mod_hi_next_o,
  output logic                       period_end_o,
  output logic                       clamp_o,
  output logic [$clog2(PRE_MOD)-1:0] a_act_o,
  output logic [B_W-1:0]             b_act_o
);
  localparam int unsigned A_W = $clog2(PRE_MOD);

  logic [A_W-1:0] a_cnt;
  logic [B_W-1:0] b_cnt;
  logic           reload;

  assign period_end_o = pre_tick_i && (b_cnt == B_W'(1));
  assign reload       = start_i || period_end_o;

  // Modulus of the group that begins at this edge.
  always_comb begin
    if (reload) mod_hi_next_o = (a_new_i != '0);
    else        mod_hi_next_o = (a_cnt > A_W'(1));
  end

  always_ff @(posedge clk_i) begin
    if (reload) begin
      a_cnt   <= a_new_i;
      b_cnt   <= b_new_i;
      clamp_o <= clamp_new_i;
      a_act_o <= a_new_i;
      b_act_o <= b_new_i;
    end else if (pre_tick_i) begin
      if (a_cnt != '0) a_cnt <= a_cnt - A_W'(1);
      b_cnt <= b_cnt - B_W'(1);
    end
  end

  // R5: clamping keeps the swallow count within the main count.
  assert_swallow_le_main_R5: assert property (@(posedge clk_i) disable iff (start_i)
    a_cnt <= b_cnt);
  // R1: the main count is never exhausted without a reload.
  assert_main_live_R1: assert property (@(posedge clk_i) disable iff (start_i)
    b_cnt != '0);
endmodule

// File: rtl/pswdiv_top.sv
module pswdiv_top #(
  parameter int unsigned PRE_MOD = pswdiv_pkg::PRE_MOD_DEF, // power of two
  parameter int unsigned B_W     = pswdiv_pkg::B_W_DEF
) (
  input  logic                           clk_i,
  input  logic                           rst_i,
  input  logic                           run_i,
  input  logic [$clog2(PRE_MOD)+B_W-1:0] ratio_i,
  output logic                           pulse_o,
  output logic                           ratio_err_o
);
  localparam int unsigned A_W   = $clog2(PRE_MOD);
  localparam int unsigned N_W   = A_W + B_W;
  localparam int unsigned CNT_W = N_W + 1;

  logic           start;
  logic           step;
  logic [A_W-1:0] a_new;
  logic [B_W-1:0] b_new;
  logic           clamp_new;
  logic           mod_hi_next;
  logic           pre_tick;
  logic           period_end;
  logic [A_W-1:0] a_act;
  logic [B_W-1:0] b_act;

  assign start = rst_i || !run_i;
  assign step  = run_i && !rst_i;

  pswdiv_ratio_guard #(.PRE_MOD(PRE_MOD), .B_W(B_W)) guard_i (
    .word_i (ratio_i),
    .a_o    (a_new),
    .b_o    (b_new),
    .clamp_o(clamp_new)
  );

  pswdiv_prescaler #(.PRE_MOD(PRE_MOD)) presc_i (
    .clk_i        (clk_i),
    .start_i      (start),
    .step_i       (step),
    .mod_hi_next_i(mod_hi_next),
    .pre_tick_o   (pre_tick)
  );

  pswdiv_swallow_seq #(.PRE_MOD(PRE_MOD), .B_W(B_W)) seq_i (
    .clk_i        (clk_i),
    .start_i      (start),
    .pre_tick_i   (pre_tick),
    .a_new_i      (a_new),
    .b_new_i      (b_new),
    .clamp_new_i  (clamp_new),
    .mod_hi_next_o(mod_hi_next),
    .period_end_o (period_end),
    .clamp_o      (ratio_err_o),
    .a_act_o      (a_act),
    .b_act_o      (b_act)
  );

  always_ff @(posedge clk_i) begin
    if (rst_i) pulse_o <= 1'b0;
    else       pulse_o <= period_end;
  end

  // Cycle counter used only by the period-length check below.
  logic [CNT_W-1:0] chk_cnt;
  always_ff @(posedge clk_i) begin
    if (start || period_end) chk_cnt <= '0;
    else                     chk_cnt <= chk_cnt + CNT_W'(1);
  end

  assert_period_len_R1: assert property (@(posedge clk_i) disable iff (start)
    period_end |-> (int'(chk_cnt) + 1 ==
                    int'(pswdiv_pkg::ratio_of(int'(b_act), int'(a_act), PRE_MOD))));

  assert_pulse_width_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    pulse_o |=> !pulse_o);

  assert_clamp_floor_R5: assert property (@(posedge clk_i) disable iff (rst_i)
    ratio_err_o |-> (pswdiv_pkg::ratio_of(int'(b_act), int'(a_act), PRE_MOD) ==
                     pswdiv_pkg::min_ratio(PRE_MOD)));

  assert_standby_quiet_R6: assert property (@(posedge clk_i) disable iff (rst_i)
    !run_i |=> !pulse_o);
endmodule

// File: tb/pswdiv_top_tb_top.sv
module pswdiv_top_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int MIN_R      = 992;

  logic        clk_i = 1'b0;
  logic        rst_i;
  logic        run_i;
  logic [15:0] ratio_i;
  logic        pulse_o;
  logic        ratio_err_o;

  int checks = 0;
  int errors = 0;
  int prev_m = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  pswdiv_top dut_i (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .run_i      (run_i),
    .ratio_i    (ratio_i),
    .pulse_o    (pulse_o),
    .ratio_err_o(ratio_err_o)
  );

  function automatic int exp_period(input int r);
    return (r < MIN_R) ? MIN_R : r;
  endfunction

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic count_to_pulse(output int n);
    n = 0;
    do begin
      @(negedge clk_i);
      n++;
    end while (!pulse_o && n < 70000);
  endtask

  // Called at the falling edge where a pulse is visible.
  task automatic step_ratio(input int r);
    int n;
    ratio_i = 16'(r);
    @(negedge clk_i);
    chk(pulse_o == 1'b0, "R2", int'(pulse_o), 0);
    count_to_pulse(n);
    n++;
    chk(n == prev_m, "R1 R4 period in flight", n, prev_m);
    chk(ratio_err_o == (r < MIN_R), "R5 error flag", int'(ratio_err_o), int'(r < MIN_R));
    prev_m = exp_period(r);
  endtask

  initial begin
    int n;
    int seen;
    rst_i   = 1'b1;
    run_i   = 1'b1;
    ratio_i = 16'd1285;
    repeat (5) @(negedge clk_i);
    chk(pulse_o == 1'b0, "R7 pulse in reset", int'(pulse_o), 0);
    chk(ratio_err_o == 1'b0, "R7 error in reset", int'(ratio_err_o), 0);
    rst_i = 1'b0;
    count_to_pulse(n);
    chk(n == 1285, "R3 first period after reset", n, 1285);
    prev_m = 1285;

    // Swallow count sweep at the smallest main count.
    for (int a = 0; a < 32; a++) step_ratio(31 * 32 + a);
    // Mixed legal and illegal words (R5 clamps).
    step_ratio(1285);
    step_ratio(0);
    step_ratio(500);
    step_ratio(991);
    step_ratio(992);
    step_ratio(200 * 32 + 17);
    step_ratio(400 * 32 + 31);
    step_ratio(63 * 32);
    step_ratio(65535);
    step_ratio(993);

    // R6: standby in the middle of a period.
    repeat (300) @(negedge clk_i);
    run_i = 1'b0;
    seen  = 0;
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk_i);
      if (i == 10) ratio_i = 16'd1000;
      if (pulse_o) seen++;
    end
    chk(seen == 0, "R6 no pulse in standby", seen, 0);
    run_i = 1'b1;
    count_to_pulse(n);
    chk(n == 1000, "R6 R3 fresh period after standby", n, 1000);
    prev_m = 1000;
    step_ratio(2500);

    // R7/R3: reset in the middle of a period.
    repeat (400) @(negedge clk_i);
    rst_i = 1'b1;
    seen  = 0;
    for (int i = 0; i < 4; i++) begin
      @(negedge clk_i);
      if (pulse_o) seen++;
    end
    chk(seen == 0, "R7 pulse held low in reset", seen, 0);
    rst_i = 1'b0;
    count_to_pulse(n);
    chk(n == 2500, "R3 first period after mid-run reset", n, 2500);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk_i);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule